// File: doc/BRIEF.md
# Clock Rate Measurement Sequencer

This block runs a complete frequency measurement on a separate window counter. The counter counts edges of the clock under test while a reference tick counter runs down. After a start pulse, the sequencer switches the divided reference branch on. It then drives the counter's control port through two measurement windows: a short one and a long one. It reads the raw edge count at the end of each window and switches the reference branch off again after the second window.

Two equal raw counts mean that the clock under test is not running, because a stopped clock leaves the counter unchanged. In that case the block reports zero and raises a clock-off flag. Otherwise it converts the long count to Hertz with an offset-corrected ratio, using a sequential restoring divider. It then scales the result by the post-divider factor, and also by the pre-set divider factor when that factor is nonzero. Every wait on the counter is guarded by a timeout.

Top module: `clk_rate_meter`

## Requirements
- R1: Each window issues, in order: a control write with `ctlRun`=0; a wait until `cntDone` is 0; a control write with `ctlRun`=1; a wait until `cntDone` is 1; a capture of `cntCount`; and a further control write with `ctlRun`=0. A write is any cycle with `ctlWr`=1, and it carries `ctlRun` and `ctlTicks`.
- R2: The first window writes `ctlTicks`=0x1000 and the second writes `ctlTicks`=0x10000. A normal measurement makes exactly six writes.
- R3: When the long count equals the short count, `done` comes with `rateHz`=0 and `clkOff`=1.
- R4: Otherwise the base rate is floor(((L*10+15)*4800000)/655395), where L is the long count and 655395 = 0x10000*10+35. In this case `clkOff`=0.
- R5: The reported `rateHz` is the base rate times `postDiv`, times `preDiv` when `preDiv` is nonzero. A zero `preDiv` leaves the value unscaled, and a zero `postDiv` gives 0.
- R6: `refEn` goes to 1 on the start pulse, before the first write. It stays at 1 during every write and is 0 by the `done` cycle.
- R7: A start pulse is ignored while `busy` is 1, and that includes the `done` cycle. Such a pulse causes no extra write and no extra `done` pulse.
- R8: `done` is a single-cycle pulse. `rateHz`, `clkOff` and `timedOut` keep their values until the next accepted start.
- R9: A wait on `cntDone` that lasts `TIMEOUT_CYC` cycles ends the run. The block then makes a write with `ctlRun`=0 and pulses `done` with `timedOut`=1, `rateHz`=0 and `refEn`=0. The next start runs normally again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Measurement request pulse |
| postDiv | input | DIV_W | Post-divider factor applied to the result |
| preDiv | input | DIV_W | Pre-set divider factor, 0 means none |
| cntDone | input | 1 | Counter window-complete status |
| cntCount | input | CNT_W | Counter raw edge count |
| ctlWr | output | 1 | Counter control write strobe |
| ctlRun | output | 1 | Counter enable value carried by a write |
| ctlTicks | output | TICK_W | Reference tick count carried by a write |
| refEn | output | 1 | Divided reference branch enable |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Result valid pulse |
| rateHz | output | QUO_W+2*DIV_W | Measured rate in Hz |
| clkOff | output | 1 | Clock under test found stopped |
| timedOut | output | 1 | Last run ended on a counter timeout |

## Verification
The completion pulse and a fresh start request can fall in the same cycle. The bench drives `start` during the `done` cycle and again midway through a run. It then judges that the only result is the one from the first run: no further control writes appear, `busy` stays low afterwards, and exactly one `done` pulse occurs. Back-to-back runs, with the counter status left high from the previous run, show that a stale completion flag is never taken as the end of the new window.

// File: rtl/crm_pkg.sv
package crm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_STOP,
    ST_WLOW,
    ST_RUN,
    ST_WHIGH,
    ST_CAP,
    ST_END,
    ST_DECIDE,
    ST_DIV,
    ST_ABORT,
    ST_FIN
  } crmState_e;

  typedef struct packed {
    logic capShort;
    logic capLong;
    logic divStart;
    logic loadRate;
    logic loadZero;
  } dpStrobe_t;

endpackage

// File: rtl/crm_divider.sv
module crm_divider #(
  parameter int NUM_W = 52,
  parameter int DEN_W = 20,
  parameter int QUO_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NUM_W-1:0] dividend,
  input  logic [DEN_W-1:0] divisor,
  output logic [QUO_W-1:0] quotient,
  output logic             finish
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] acc;
  logic [DEN_W-1:0] rem;
  logic [CNT_W-1:0] stepsLeft;
  logic [DEN_W:0]   shifted;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign shifted = {rem, acc[NUM_W-1]};
  assign trial   = shifted - {1'b0, divisor};
  assign fits    = shifted >= {1'b0, divisor};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      rem       <= '0;
      stepsLeft <= '0;
      finish    <= 1'b0;
    end else begin
      finish <= 1'b0;
      if (start) begin
        acc       <= dividend;
        rem       <= '0;
        stepsLeft <= CNT_W'(NUM_W);
      end else if (stepsLeft != '0) begin
        rem       <= fits ? trial[DEN_W-1:0] : shifted[DEN_W-1:0];
        acc       <= {acc[NUM_W-2:0], fits};
        stepsLeft <= stepsLeft - 1'b1;
        finish    <= (stepsLeft == CNT_W'(1));
      end
    end
  end

  assign quotient = acc[QUO_W-1:0];

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rstN)
    (stepsLeft != '0) |-> (rem < divisor)); // R4

endmodule

// File: rtl/crm_ctrl.sv
module crm_ctrl
  import crm_pkg::*;
#(
  parameter int          TICK_W      = 17,
  parameter logic [TICK_W-1:0] SHORT_TICKS = 17'h01000,
  parameter logic [TICK_W-1:0] LONG_TICKS  = 17'h10000,
  parameter int          TIMEOUT_CYC = 100000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              cntDone,
  input  logic              countsEqual,
  input  logic              divFinish,
  output dpStrobe_t         stb,
  output logic              ctlWr,
  output logic              ctlRun,
  output logic [TICK_W-1:0] ctlTicks,
  output logic              refEn,
  output logic              busy,
  output logic              done,
  output logic              clkOff,
  output logic              timedOut
);
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);

  crmState_e       state, nxt;
  logic            winLong;
  logic [TMO_W-1:0] tmoCnt;
  logic            tmoHit;
  logic            waiting;

  assign waiting = (state == ST_WLOW) || (state == ST_WHIGH);
  assign tmoHit  = (tmoCnt == TMO_W'(TIMEOUT_CYC - 1));

  always_comb begin
    nxt    = state;
    stb    = '0;
    ctlWr  = 1'b0;
    ctlRun = 1'b0;
    unique case (state)
      ST_IDLE:   if (start) nxt = ST_STOP;
      ST_STOP:   begin ctlWr = 1'b1; nxt = ST_WLOW; end
      ST_WLOW: begin
        if (!cntDone)    nxt = ST_RUN;
        else if (tmoHit) nxt = ST_ABORT;
      end
      ST_RUN:    begin ctlWr = 1'b1; ctlRun = 1'b1; nxt = ST_WHIGH; end
      ST_WHIGH: begin
        if (cntDone)     nxt = ST_CAP;
        else if (tmoHit) nxt = ST_ABORT;
      end
      ST_CAP: begin
        stb.capShort = !winLong;
        stb.capLong  = winLong;
        nxt          = ST_END;
      end
      ST_END:    begin ctlWr = 1'b1; nxt = winLong ? ST_DECIDE : ST_STOP; end
      ST_DECIDE: begin
        if (countsEqual) begin stb.loadZero = 1'b1; nxt = ST_FIN; end
        else             begin stb.divStart = 1'b1; nxt = ST_DIV; end
      end
      ST_DIV:    if (divFinish) begin stb.loadRate = 1'b1; nxt = ST_FIN; end
      ST_ABORT:  begin ctlWr = 1'b1; stb.loadZero = 1'b1; nxt = ST_FIN; end
      ST_FIN:    nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tmoCnt   <= '0;
      winLong  <= 1'b0;
      refEn    <= 1'b0;
      clkOff   <= 1'b0;
      timedOut <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state)  tmoCnt <= '0;
      else if (waiting)  tmoCnt <= tmoCnt + 1'b1;
      if (state == ST_IDLE && start) begin
        refEn    <= 1'b1;
        winLong  <= 1'b0;
        clkOff   <= 1'b0;
        timedOut <= 1'b0;
      end
      if (state == ST_END && !winLong) winLong <= 1'b1;
      if ((state == ST_END && winLong) || state == ST_ABORT) refEn <= 1'b0;
      if (state == ST_DECIDE && countsEqual) clkOff <= 1'b1;
      if (nxt == ST_ABORT && state != ST_ABORT) timedOut <= 1'b1;
    end
  end

  assign ctlTicks = winLong ? LONG_TICKS : SHORT_TICKS;
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FIN);

  AST_RUN_AFTER_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && ctlRun) |-> $past(!cntDone)); // R1
  AST_REF_DURING_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && ctlRun) |-> refEn); // R6
  AST_REF_OFF_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !refEn); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && start) |=> busy); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timedOut) |-> (ctlWr && !ctlRun)); // R9

endmodule

// File: rtl/crm_dpath.sv
module crm_dpath
  import crm_pkg::*;
#(
  parameter int CNT_W     = 25,
  parameter int DIV_W     = 8,
  parameter int QUO_W     = 32,
  parameter int REF_HZ    = 4800000,
  parameter int TICK_BIAS = 15,
  parameter int DIVISOR   = 655395
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                stb,
  input  logic [CNT_W-1:0]         cntCount,
  input  logic [DIV_W-1:0]         postDiv,
  input  logic [DIV_W-1:0]         preDiv,
  output logic                     countsEqual,
  output logic                     divFinish,
  output logic [QUO_W+2*DIV_W-1:0] rateHz
);
  localparam int RATE_W = QUO_W + 2 * DIV_W;
  localparam int NUM_W  = CNT_W + 4 + $clog2(REF_HZ + 1);
  localparam int DEN_W  = $clog2(DIVISOR + 1);

  logic [CNT_W-1:0]  shortCnt, longCnt;
  logic [NUM_W-1:0]  numer;
  logic [QUO_W-1:0]  quo;
  logic [DIV_W-1:0]  preEff;
  logic [RATE_W-1:0] scaled;

  assign numer = (NUM_W'(longCnt) * NUM_W'(10) + NUM_W'(TICK_BIAS)) * NUM_W'(REF_HZ);

  crm_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W), .QUO_W(QUO_W)) uDiv (
    .clk      (clk),
    .rstN     (rstN),
    .start    (stb.divStart),
    .dividend (numer),
    .divisor  (DEN_W'(DIVISOR)),
    .quotient (quo),
    .finish   (divFinish)
  );

  assign preEff = (preDiv != '0) ? preDiv : DIV_W'(1);
  assign scaled = RATE_W'(quo) * RATE_W'(postDiv) * RATE_W'(preEff);
  assign countsEqual = (shortCnt == longCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shortCnt <= '0;
      longCnt  <= '0;
      rateHz   <= '0;
    end else begin
      if (stb.capShort) shortCnt <= cntCount;
      if (stb.capLong)  longCnt  <= cntCount;
      if (stb.loadZero)      rateHz <= '0;
      else if (stb.loadRate) rateHz <= scaled;
    end
  end

  AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.capShort && stb.capLong)); // R1
  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.loadZero && stb.loadRate)); // R3

endmodule

// File: rtl/clk_rate_meter.sv
module clk_rate_meter
  import crm_pkg::*;
#(
  parameter int CNT_W       = 25,
  parameter int TICK_W      = 17,
  parameter int SHORT_TICKS = 'h01000,
  parameter int LONG_TICKS  = 'h10000,
  parameter int REF_HZ      = 4800000,
  parameter int TICK_BIAS   = 15,
  parameter int WIN_BIAS    = 35,
  parameter int DIV_W       = 8,
  parameter int QUO_W       = 32,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [DIV_W-1:0]         postDiv,
  input  logic [DIV_W-1:0]         preDiv,
  input  logic                     cntDone,
  input  logic [CNT_W-1:0]         cntCount,
  output logic                     ctlWr,
  output logic                     ctlRun,
  output logic [TICK_W-1:0]        ctlTicks,
  output logic                     refEn,
  output logic                     busy,
  output logic                     done,
  output logic [QUO_W+2*DIV_W-1:0] rateHz,
  output logic                     clkOff,
  output logic                     timedOut
);
  localparam int DIVISOR = LONG_TICKS * 10 + WIN_BIAS;

  dpStrobe_t stb;
  logic      countsEqual;
  logic      divFinish;

  crm_ctrl #(
    .TICK_W      (TICK_W),
    .SHORT_TICKS (TICK_W'(SHORT_TICKS)),
    .LONG_TICKS  (TICK_W'(LONG_TICKS)),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .cntDone     (cntDone),
    .countsEqual (countsEqual),
    .divFinish   (divFinish),
    .stb         (stb),
    .ctlWr       (ctlWr),
    .ctlRun      (ctlRun),
    .ctlTicks    (ctlTicks),
    .refEn       (refEn),
    .busy        (busy),
    .done        (done),
    .clkOff      (clkOff),
    .timedOut    (timedOut)
  );

  crm_dpath #(
    .CNT_W     (CNT_W),
    .DIV_W     (DIV_W),
    .QUO_W     (QUO_W),
    .REF_HZ    (REF_HZ),
    .TICK_BIAS (TICK_BIAS),
    .DIVISOR   (DIVISOR)
  ) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .cntCount    (cntCount),
    .postDiv     (postDiv),
    .preDiv      (preDiv),
    .countsEqual (countsEqual),
    .divFinish   (divFinish),
    .rateHz      (rateHz)
  );

  AST_OFF_MEANS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (done && clkOff) |-> (rateHz == '0)); // R3
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(rateHz)); // R8

endmodule

// File: tb/clk_rate_meter_test.sv
module clk_rate_meter_test;
  localparam int SHORT_T = 'h01000;
  localparam int LONG_T  = 'h10000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  postDiv = 8'd1;
  logic [7:0]  preDiv = 8'd0;
  logic        cntDone = 1'b1;
  logic [24:0] cntCount = '0;
  logic        ctlWr, ctlRun, refEn, busy, done, clkOff, timedOut;
  logic [16:0] ctlTicks;
  logic [47:0] rateHz;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  clk_rate_meter #(.TIMEOUT_CYC(64)) uut (
    .clk(clk), .rstN(rstN), .start(start), .postDiv(postDiv), .preDiv(preDiv),
    .cntDone(cntDone), .cntCount(cntCount), .ctlWr(ctlWr), .ctlRun(ctlRun),
    .ctlTicks(ctlTicks), .refEn(refEn), .busy(busy), .done(done),
    .rateHz(rateHz), .clkOff(clkOff), .timedOut(timedOut)
  );

  // counter model, acting on falling edges
  logic [24:0] mShort, mLong;
  bit          stuck = 0;
  int          lowDly = 0, hiDly = 0;
  logic [17:0] wrLog [16];
  bit          wrRef [16];
  int          logN = 0;
  int          doneCnt = 0;

  always @(negedge clk) begin
    if (done) doneCnt++;
    if (ctlWr) begin
      if (logN < 16) begin
        wrLog[logN] = {ctlRun, ctlTicks};
        wrRef[logN] = refEn;
      end
      logN++;
      if (!ctlRun) begin lowDly = 3; hiDly = 0; end
      else hiDly = 5;
    end else begin
      if (lowDly > 0) begin
        lowDly--;
        if (lowDly == 0 && !stuck) cntDone = 1'b0;
      end
      if (hiDly > 0) begin
        hiDly--;
        if (hiDly == 0) begin
          cntDone  = 1'b1;
          cntCount = (ctlTicks == 17'(SHORT_T)) ? mShort : mLong;
        end
      end
    end
  end

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint unsigned expRate(input longint unsigned sv, lv, pd, pre);
    longint unsigned q;
    if (sv == lv) return 0;
    q = ((lv * 10 + 15) * 4800000) / 655395;
    return q * pd * ((pre != 0) ? pre : 1);
  endfunction

  longint unsigned gotRate;
  bit gotOff, gotTo, gotRef, gotDone;

  task automatic runMeas(input logic [24:0] sv, lv, input logic [7:0] pd, pre,
                         input bit midStart, input bit stk);
    @(negedge clk);
    mShort = sv; mLong = lv; postDiv = pd; preDiv = pre;
    stuck = stk; cntDone = 1'b1; logN = 0; doneCnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    gotDone = 0;
    for (int i = 0; i < 3000; i++) begin
      if (midStart && i == 8) start = 1'b1;
      if (midStart && i == 9) start = 1'b0;
      if (done) begin gotDone = 1; break; end
      @(negedge clk);
    end
    gotRate = rateHz; gotOff = clkOff; gotTo = timedOut; gotRef = refEn;
  endtask

  localparam logic [24:0] V_SHORT [7] = '{25'h100, 25'd123, 25'd5, 25'd10, 25'd0, 25'd1, 25'd7};
  localparam logic [24:0] V_LONG  [7] = '{25'h1000, 25'h1FFFFFF, 25'd5, 25'd40000, 25'd0, 25'd0, 25'd1};
  localparam logic [7:0]  V_POST  [7] = '{8'd1, 8'd1, 8'd4, 8'd3, 8'd1, 8'd255, 8'd0};
  localparam logic [7:0]  V_PRE   [7] = '{8'd0, 8'd0, 8'd0, 8'd2, 8'd5, 8'd255, 8'd9};

  task automatic chkLog(input string tag);
    logic [17:0] e [6];
    e[0] = {1'b0, 17'(SHORT_T)}; e[1] = {1'b1, 17'(SHORT_T)}; e[2] = {1'b0, 17'(SHORT_T)};
    e[3] = {1'b0, 17'(LONG_T)};  e[4] = {1'b1, 17'(LONG_T)};  e[5] = {1'b0, 17'(LONG_T)};
    chk({tag, " R2 write count"}, logN, 6);
    for (int k = 0; k < 6; k++) begin
      chk({tag, " R1 R2 write order"}, wrLog[k], e[k]);
      chk({tag, " R6 refEn at write"}, wrRef[k], 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk("reset busy", busy, 0);
    chk("reset done R8", done, 0);
    chk("reset refEn R6", refEn, 0);
    chk("reset ctlWr R1", ctlWr, 0);
    chk("reset rateHz", rateHz, 0);
    chk("reset clkOff R3", clkOff, 0);
    chk("reset timedOut R9", timedOut, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 7; v++) begin
      runMeas(V_SHORT[v], V_LONG[v], V_POST[v], V_PRE[v], 0, 0);
      chk("R8 done seen", gotDone, 1);
      chk("R4 R5 rate", gotRate, expRate(V_SHORT[v], V_LONG[v], V_POST[v], V_PRE[v]));
      chk("R3 clkOff", gotOff, (V_SHORT[v] == V_LONG[v]) ? 1 : 0);
      chk("R9 no timeout", gotTo, 0);
      chk("R6 refEn low at done", gotRef, 0);
      chkLog("vec");
    end

    // start in the done cycle and mid-run are ignored
    runMeas(25'd50, 25'd900, 8'd2, 8'd0, 1, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    chk("R7 busy after start in done cycle", busy, 0);
    chk("R7 single done", doneCnt, 1);
    chk("R7 no extra writes", logN, 6);
    chk("R4 R7 rate kept", rateHz, expRate(50, 900, 2, 0));
    chk("R8 done one cycle", done, 0);

    // timeout on a counter whose status never clears
    runMeas(25'd1, 25'd2, 8'd1, 8'd0, 0, 1);
    chk("R9 done on timeout", gotDone, 1);
    chk("R9 timedOut", gotTo, 1);
    chk("R9 rate zero", gotRate, 0);
    chk("R9 refEn low", gotRef, 0);
    chk("R9 stop write", logN, 2);
    chk("R9 stop write run low", wrLog[1][17], 0);
    repeat (5) @(negedge clk);
    chk("R8 timedOut held", timedOut, 1);

    // recovery
    runMeas(25'd300, 25'd77777, 8'd1, 8'd3, 0, 0);
    chk("R9 recovery timedOut", gotTo, 0);
    chk("R9 R5 recovery rate", gotRate, expRate(300, 77777, 1, 3));
    chkLog("recovery");

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule